// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of a small direct-mapped group of one-word cache lines for one core. Each line holds a tag, a data word and a two-bit state. Local loads and stores are served from the line when they hit. Otherwise the controller raises one request on a shared bus: a line read, an ownership (invalidate) request, a write-through store or a write-back of a dirty victim.

At the same time, the controller watches the bus operations that other cores are granted. It answers with a shared indication. If it owns the snooped line in the modified state, it also answers with a hit-modified flag and the line's data. The data is offered in the same cycle, so it can go straight to the requester and to memory.

Several controllers share one bus. The arbiter grants one request per cycle and shows that request as a snoop to every other controller.

Top module: `coh_line_ctrl`

## Requirements
- R1: State encoding is 2'b00 Invalid, 2'b01 Shared, 2'b10 Exclusive, 2'b11 Modified. After reset every line is Invalid and no bus request is raised.
- R2: A local load that misses raises a bus request of kind 0 (line read). When granted, the line takes the fill data and becomes Exclusive if `bus_shared_in` is low, or Shared if it is high.
- R3: A local store to a line held Modified or Exclusive with a matching tag completes with no bus request, and the line ends Modified.
- R4: A local store to a Shared line raises a request of kind 1 (ownership). When granted, the line ends Modified and holds the stored word.
- R5: A local store that misses raises a request of kind 2 (write-through) carrying the address and word. The indexed line keeps its state and tag.
- R6: A snooped kind 1 or kind 2 hitting a Shared or Exclusive line makes it Invalid. A snooped kind 0 turns Exclusive into Shared and leaves Shared unchanged.
- R7: A snooped kind 0, 1 or 2 hitting a Modified line raises `snp_hitm` and `wb_valid` with the line word in the same cycle. The line then becomes Shared for kind 0 and Invalid otherwise.
- R8: `snp_shared` is high in any cycle where a snoop matches a valid line.
- R9: A load that misses on an index whose line is Modified under another tag first writes that line back (kind 3). Only then does it issue the line read.
- R10: A snoop to the same index as a waiting local request wins the cycle. The local request is taken one cycle later.
- R11: With two controllers on one bus, no address is Modified or Exclusive in one while valid in the other, and every load returns the latest stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| loc_valid | input | 1 | Local request, held until `loc_done` |
| loc_write | input | 1 | 1 = store, 0 = load |
| loc_addr | input | ADDR_W | Word address of the local request |
| loc_wdata | input | DATA_W | Store data |
| loc_done | output | 1 | One-cycle completion pulse |
| loc_rdata | output | DATA_W | Load result, valid with `loc_done` |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_kind | output | 2 | 0 read, 1 ownership, 2 write-through, 3 write-back |
| bus_req_addr | output | ADDR_W | Request address |
| bus_req_data | output | DATA_W | Word for kinds 1 to 3 |
| bus_gnt | input | 1 | Request granted this cycle |
| bus_fill_data | input | DATA_W | Fill word for a granted read |
| bus_shared_in | input | 1 | Another cache holds the line being read |
| snp_valid | input | 1 | Snooped operation present |
| snp_kind | input | 2 | Snooped kind, same coding as requests |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | Snoop matches a valid line |
| snp_hitm | output | 1 | Snoop matches a Modified line |
| wb_valid | output | 1 | Implicit write-back word offered |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back word |
| probe_state | output | 2*LINES | Per-line state, line i at bits [2i+1:2i] |
| probe_tag | output | TAG_W*LINES | Per-line tag, line i at [TAG_W*i +: TAG_W] |

## Verification
A local request and a snoop can reach the same line index in the same cycle. The snoop's state change and the local hit would then both write that line.

The bench provokes this with two requests to one index. It starts the peer's bus request one cycle before the local load. The peer's grant is then delivered as a snoop exactly when the local load first appears.

The load's latency must come out one cycle longer than a plain hit, and its data must still match the reference. Coherence in both caches is checked on every cycle by the exclusivity monitor.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        BK_READ  = 2'd0,
        BK_OWN   = 2'd1,
        BK_WRITE = 2'd2,
        BK_WB    = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        LA_HIT_RD,
        LA_HIT_WR,
        LA_OWN,
        LA_WRITE,
        LA_READ,
        LA_WB
    } loc_act_e;

endpackage

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
    import coh_pkg::*;
(
    input  logic      valid,
    input  logic [1:0] kind,
    input  mesi_e     st,
    input  logic      tag_hit,
    output logic      hit,
    output logic      hitm,
    output mesi_e     st_next
);
    always_comb begin
        hit     = valid && tag_hit && (st != ST_I) && (kind != BK_WB);
        hitm    = hit && (st == ST_M);
        st_next = st;
        if (hit) begin
            if (kind == BK_READ) st_next = ST_S;
            else                 st_next = ST_I;
        end
    end
endmodule

// File: rtl/coh_local_dec.sv
module coh_local_dec
    import coh_pkg::*;
(
    input  logic     is_write,
    input  mesi_e    st,
    input  logic     tag_hit,
    output loc_act_e act
);
    logic present;

    always_comb begin
        present = tag_hit && (st != ST_I);
        if (is_write) begin
            if (present && (st == ST_M || st == ST_E)) act = LA_HIT_WR;
            else if (present)                          act = LA_OWN;
            else                                       act = LA_WRITE;
        end else begin
            if (present)            act = LA_HIT_RD;
            else if (st == ST_M)    act = LA_WB;
            else                    act = LA_READ;
        end
    end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loc_valid,
    input  logic                    loc_write,
    input  logic [ADDR_W-1:0]       loc_addr,
    input  logic [DATA_W-1:0]       loc_wdata,
    output logic                    loc_done,
    output logic [DATA_W-1:0]       loc_rdata,
    output logic                    bus_req_valid,
    output logic [1:0]              bus_req_kind,
    output logic [ADDR_W-1:0]       bus_req_addr,
    output logic [DATA_W-1:0]       bus_req_data,
    input  logic                    bus_gnt,
    input  logic [DATA_W-1:0]       bus_fill_data,
    input  logic                    bus_shared_in,
    input  logic                    snp_valid,
    input  logic [1:0]              snp_kind,
    input  logic [ADDR_W-1:0]       snp_addr,
    output logic                    snp_shared,
    output logic                    snp_hitm,
    output logic                    wb_valid,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [DATA_W-1:0]       wb_data,
    output logic [2*LINES-1:0]      probe_state,
    output logic [(ADDR_W-$clog2(LINES))*LINES-1:0] probe_tag
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic [LINES-1:0][1:0]        st;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] data;
        logic                         busy;
        logic [1:0]                   kind;
        logic [ADDR_W-1:0]            addr;
        logic [DATA_W-1:0]            wdata;
        logic                         done;
        logic [DATA_W-1:0]            rdata;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0] sidx, lidx, ridx;
    logic [TAG_W-1:0] stag, ltag, rtag;
    logic             s_hit, s_hitm, go;
    mesi_e            s_next;
    loc_act_e         act;

    assign sidx = snp_addr[IDX_W-1:0];
    assign stag = snp_addr[ADDR_W-1:IDX_W];
    assign lidx = loc_addr[IDX_W-1:0];
    assign ltag = loc_addr[ADDR_W-1:IDX_W];
    assign ridx = q.addr[IDX_W-1:0];
    assign rtag = q.addr[ADDR_W-1:IDX_W];

    coh_snoop_resp u_snoop (
        .valid   (snp_valid),
        .kind    (snp_kind),
        .st      (mesi_e'(q.st[sidx])),
        .tag_hit (q.tag[sidx] == stag),
        .hit     (s_hit),
        .hitm    (s_hitm),
        .st_next (s_next)
    );

    coh_local_dec u_local (
        .is_write (loc_write),
        .st       (mesi_e'(q.st[lidx])),
        .tag_hit  (q.tag[lidx] == ltag),
        .act      (act)
    );

    // a snoop to the same index blocks local acceptance (R10)
    assign go = loc_valid && !q.busy && !q.done && !(snp_valid && sidx == lidx);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (s_hit) d.st[sidx] = s_next;
        // pending write-back lost its dirty line to a snoop: go straight to the read
        if (q.busy && q.kind == BK_WB && s_hitm && sidx == ridx) begin
            d.kind = BK_READ;
            d.addr = loc_addr;
        end
        if (go) begin
            case (act)
                LA_HIT_RD: begin
                    d.done  = 1'b1;
                    d.rdata = q.data[lidx];
                end
                LA_HIT_WR: begin
                    d.st[lidx]   = ST_M;
                    d.data[lidx] = loc_wdata;
                    d.done       = 1'b1;
                end
                LA_OWN: begin
                    d.busy = 1'b1; d.kind = BK_OWN;
                    d.addr = loc_addr; d.wdata = loc_wdata;
                end
                LA_WRITE: begin
                    d.busy = 1'b1; d.kind = BK_WRITE;
                    d.addr = loc_addr; d.wdata = loc_wdata;
                end
                LA_READ: begin
                    d.busy = 1'b1; d.kind = BK_READ;
                    d.addr = loc_addr;
                end
                default: begin
                    d.busy  = 1'b1; d.kind = BK_WB;
                    d.addr  = {q.tag[lidx], lidx};
                    d.wdata = q.data[lidx];
                end
            endcase
        end
        if (q.busy && bus_gnt) begin
            case (q.kind)
                BK_READ: begin
                    d.st[ridx]   = bus_shared_in ? ST_S : ST_E;
                    d.tag[ridx]  = rtag;
                    d.data[ridx] = bus_fill_data;
                    d.rdata      = bus_fill_data;
                    d.done       = 1'b1;
                    d.busy       = 1'b0;
                end
                BK_OWN: begin
                    d.st[ridx]   = ST_M;
                    d.tag[ridx]  = rtag;
                    d.data[ridx] = q.wdata;
                    d.done       = 1'b1;
                    d.busy       = 1'b0;
                end
                BK_WRITE: begin
                    d.done = 1'b1;
                    d.busy = 1'b0;
                end
                default: begin
                    d.st[ridx] = ST_I;
                    d.kind     = BK_READ;
                    d.addr     = loc_addr;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign loc_done      = q.done;
    assign loc_rdata     = q.rdata;
    assign bus_req_valid = q.busy;
    assign bus_req_kind  = q.kind;
    assign bus_req_addr  = q.addr;
    assign bus_req_data  = q.wdata;
    assign snp_shared    = s_hit;
    assign snp_hitm      = s_hitm;
    assign wb_valid      = s_hitm;
    assign wb_addr       = snp_addr;
    assign wb_data       = q.data[sidx];

    for (genvar i = 0; i < LINES; i++) begin : g_probe
        assign probe_state[2*i +: 2]     = q.st[i];
        assign probe_tag[TAG_W*i +: TAG_W] = q.tag[i];
    end

    a_r3_store_hit_makes_m: assert property (@(posedge clk) disable iff (!rst_n)
        (go && act == LA_HIT_WR) |=> (q.st[$past(lidx)] == ST_M && !q.busy));

    a_r4_own_only_from_s_or_i: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.kind == BK_OWN) |-> (q.st[ridx] == ST_S || q.st[ridx] == ST_I));

    a_r7_read_snoop_on_m_to_s: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hitm && snp_kind == BK_READ && !(q.busy && bus_gnt)) |=> (q.st[$past(sidx)] == ST_S));

    a_r9_writeback_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && bus_gnt && q.kind == BK_WB) |=> (q.busy && q.kind == BK_READ));

    a_r10_snoop_wins_index: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && snp_valid && sidx == lidx && !q.busy && !q.done) |=> !q.done);

endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NL = 4;
    localparam int TW = 4;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic lv_a = 0, lw_a = 0, lv_b = 0, lw_b = 0;
    logic [AW-1:0] la_a = '0, la_b = '0;
    logic [DW-1:0] lwd_a = '0, lwd_b = '0;
    logic ld_a, ld_b, req_a, req_b, sh_a, sh_b, hm_a, hm_b, wv_a, wv_b;
    logic [DW-1:0] lrd_a, lrd_b, rd_a, rd_b, wd_a, wd_b;
    logic [1:0] k_a, k_b;
    logic [AW-1:0] ra_a, ra_b, wa_a, wa_b;
    logic [2*NL-1:0] ps_a, ps_b;
    logic [TW*NL-1:0] pt_a, pt_b;
    logic gnt_a, gnt_b, prio = 0;
    logic [DW-1:0] mem [64];
    logic [DW-1:0] gold [64];
    int tests = 0, fails = 0, excl_fail = 0;

    assign gnt_a = req_a && (!prio || !req_b);
    assign gnt_b = req_b && !gnt_a;

    coh_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .loc_valid(lv_a), .loc_write(lw_a), .loc_addr(la_a),
        .loc_wdata(lwd_a), .loc_done(ld_a), .loc_rdata(lrd_a), .bus_req_valid(req_a),
        .bus_req_kind(k_a), .bus_req_addr(ra_a), .bus_req_data(rd_a), .bus_gnt(gnt_a),
        .bus_fill_data(hm_b ? wd_b : mem[ra_a]), .bus_shared_in(sh_b),
        .snp_valid(gnt_b), .snp_kind(k_b), .snp_addr(ra_b), .snp_shared(sh_a),
        .snp_hitm(hm_a), .wb_valid(wv_a), .wb_addr(wa_a), .wb_data(wd_a),
        .probe_state(ps_a), .probe_tag(pt_a));

    coh_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) peer (
        .clk(clk), .rst_n(rst_n), .loc_valid(lv_b), .loc_write(lw_b), .loc_addr(la_b),
        .loc_wdata(lwd_b), .loc_done(ld_b), .loc_rdata(lrd_b), .bus_req_valid(req_b),
        .bus_req_kind(k_b), .bus_req_addr(ra_b), .bus_req_data(rd_b), .bus_gnt(gnt_b),
        .bus_fill_data(hm_a ? wd_a : mem[ra_b]), .bus_shared_in(sh_a),
        .snp_valid(gnt_a), .snp_kind(k_a), .snp_addr(ra_a), .snp_shared(sh_b),
        .snp_hitm(hm_b), .wb_valid(wv_b), .wb_addr(wa_b), .wb_data(wd_b),
        .probe_state(ps_b), .probe_tag(pt_b));

    // shared memory: implicit write-back first, then the granted store
    always @(posedge clk) begin
        prio <= ~prio;
        if (gnt_a) begin
            if (wv_b) mem[wa_b] <= wd_b;
            if (k_a == 2'd2 || k_a == 2'd3) mem[ra_a] <= rd_a;
        end
        if (gnt_b) begin
            if (wv_a) mem[wa_a] <= wd_a;
            if (k_b == 2'd2 || k_b == 2'd3) mem[ra_b] <= rd_b;
        end
    end

    function automatic logic [1:0] st_of(input logic [2*NL-1:0] v, input int i);
        return v[2*i +: 2];
    endfunction

    function automatic logic [TW-1:0] tag_of(input logic [TW*NL-1:0] v, input int i);
        return v[TW*i +: TW];
    endfunction

    // R11: owned state in one cache excludes any valid copy in the other
    always @(negedge clk) if (rst_n) begin
        for (int i = 0; i < NL; i++) begin
            if (tag_of(pt_a, i) == tag_of(pt_b, i) && st_of(ps_a, i) != 2'b00 &&
                st_of(ps_b, i) != 2'b00 &&
                (st_of(ps_a, i)[1] || st_of(ps_b, i)[1])) excl_fail++;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic drive(input bit side, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                         output logic [3:0] kmask, output bit hit_other, output int lat);
        kmask = '0; hit_other = 0; lat = 0;
        if (!side) begin lv_a = 1; lw_a = wr; la_a = a; lwd_a = wd; end
        else       begin lv_b = 1; lw_b = wr; la_b = a; lwd_b = wd; end
        do begin
            @(negedge clk);
            lat++;
            if (!side && req_a) kmask[k_a] = 1'b1;
            if (side && req_b)  kmask[k_b] = 1'b1;
            if (!side && hm_b)  hit_other = 1;
            if (side && hm_a)   hit_other = 1;
        end while (!(side ? ld_b : ld_a));
        rd = side ? lrd_b : lrd_a;
        if (!side) lv_a = 0; else lv_b = 0;
        if (wr) gold[a] = wd;
        else chk("R11 load value", rd, gold[a]);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd, rd2;
        logic [3:0] km, km2;
        bit ho, ho2;
        int lat, lat2;
        for (int i = 0; i < 64; i++) begin mem[i] = '0; gold[i] = '0; end
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset states", {ps_a, ps_b}, '0);
        chk("R1 no request after reset", {req_a, req_b}, 2'b00);

        drive(0, 0, 6'h05, 0, rd, km, ho, lat);
        chk("R2 read miss kind", km, 4'b0001);
        chk("R2 fill exclusive", st_of(ps_a, 1), 2'b10);

        drive(0, 1, 6'h05, 16'h1111, rd, km, ho, lat);
        chk("R3 no bus on E store", km, 4'b0000);
        chk("R3 line modified", st_of(ps_a, 1), 2'b11);

        drive(1, 0, 6'h05, 0, rd, km, ho, lat);
        chk("R7 hitm on read of M", ho, 1);
        chk("R7 data from owner", rd, 16'h1111);
        chk("R7 owner to S", st_of(ps_a, 1), 2'b01);
        chk("R8 shared fill to S", st_of(ps_b, 1), 2'b01);

        drive(0, 1, 6'h05, 16'h2222, rd, km, ho, lat);
        chk("R4 ownership kind", km, 4'b0010);
        chk("R4 line modified", st_of(ps_a, 1), 2'b11);
        chk("R6 peer S invalidated", st_of(ps_b, 1), 2'b00);

        drive(0, 1, 6'h09, 16'h3333, rd, km, ho, lat);
        chk("R5 write-through kind", km, 4'b0100);
        chk("R5 line untouched", {st_of(ps_a, 1), tag_of(pt_a, 1)}, {2'b11, 4'd1});

        drive(0, 0, 6'h09, 0, rd, km, ho, lat);
        chk("R9 writeback then read", km, 4'b1001);
        chk("R9 new line exclusive", {st_of(ps_a, 1), tag_of(pt_a, 1)}, {2'b10, 4'd2});

        drive(1, 0, 6'h05, 0, rd, km, ho, lat);
        chk("R9 victim reached memory", rd, 16'h2222);

        drive(1, 1, 6'h09, 16'h4444, rd, km, ho, lat);
        chk("R6 snooped write drops E", st_of(ps_a, 1), 2'b00);

        drive(0, 0, 6'h02, 0, rd, km, ho, lat);
        fork
            drive(1, 1, 6'h06, 16'h0abc, rd2, km2, ho2, lat2);
            begin
                @(negedge clk);
                drive(0, 0, 6'h02, 0, rd, km, ho, lat);
            end
        join
        chk("R10 local delayed by snoop", lat, 2);

        drive(0, 1, 6'h02, 16'h5555, rd, km, ho, lat);
        drive(1, 1, 6'h02, 16'h6666, rd, km, ho, lat);
        chk("R7 hitm on snooped write", ho, 1);
        chk("R7 owner invalid", st_of(ps_a, 2), 2'b00);
        drive(0, 0, 6'h02, 0, rd, km, ho, lat);
        chk("R7 later store wins", rd, 16'h6666);

        fork
            for (int n = 0; n < 300; n++) begin
                logic [DW-1:0] r1; logic [3:0] m1; bit h1; int t1;
                drive(0, 1'($urandom % 2), 6'($urandom % 8), 16'($urandom), r1, m1, h1, t1);
            end
            for (int n = 0; n < 300; n++) begin
                logic [DW-1:0] r2; logic [3:0] m2; bit h2; int t2;
                drive(1, 1'($urandom % 2), 6'($urandom % 8), 16'($urandom), r2, m2, h2, t2);
            end
        join

        chk("R11 exclusivity violations", excl_fail, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule